// File: doc/BRIEF.md
# NAND Flash Bus Operation Engine

This block runs single primitive operations on an 8-bit raw NAND flash bus for a processor that programs it through a small 16-bit register port. Software puts a command byte or an address byte into a holding register and then writes one operation bit into the control register. The engine then runs that one bus primitive: a command latch, an address latch, a transfer of one 512-byte buffer section to the flash or from the flash, a device ID read, or a status read.

When the primitive is done, the engine sets a sticky completion flag. An interrupt output follows that flag unless it is masked. The internal buffer holds several 512-byte sections, and the host reaches it through a separate word port. Transfers to and from the flash use the section named in the section-select register. ID and status results always land in section 0.

Strobe low and high widths are parameters given in clock cycles. The ready/busy pin passes through a two-flop synchroniser. It gates the start of a read-out and the end of every operation.

Top module: `nand_op_engine`

## Requirements
- R1: After reset, every register reads 0, including completion (bit 15) and busy (bit 14) of the control register. Chip enable, WE# and RE# are high, CLE and ALE are low, and the interrupt output is low.
- R2: Writing bit 0 of the control register (byte offset 0x1C) runs a command latch. CLE is high for T_LOW+T_HIGH cycles around a single WE# pulse. WE# is low for T_LOW cycles, and the data bus carries the low byte of the command register (offset 0x08).
- R3: Writing bit 1 runs an address latch. ALE is high and CLE is low around a single WE# pulse, and the data bus carries the low byte of the address register (offset 0x06).
- R4: Bit 15 of the control register is set when an operation finishes. A control-register write with bit 15 at 0 clears it. A write with bit 15 at 1 leaves it set.
- R5: The interrupt output is high exactly while the completion bit is set and bit 4 of the configuration register (offset 0x1A) is 0.
- R6: Bit 3 runs a read-out. The engine first waits for R/B# to be high. It then gives SECT_BYTES RE# pulses and stores the bytes into the section named at offset 0x04. With configuration bit 5 at 0, the first byte of each pair goes to bits 7:0 of the word. With bit 5 at 1, the first byte goes to bits 15:8.
- R7: Bit 2 runs a write-in. The engine gives SECT_BYTES WE# pulses, with CLE and ALE low, and sends the selected section in the same byte order as R6.
- R8: Bit 4 runs an ID read. The engine gives ID_BEATS RE# pulses and writes beat k into word k of section 0 as {8'h00, byte}. Words past ID_BEATS-1 are left untouched.
- R9: Bit 5 runs a status read. The engine gives one RE# pulse and writes {8'h00, byte} into word 0 of section 0. Word 1 is left untouched.
- R10: After the last strobe of any operation, the engine waits T_WB cycles. It does not set the completion bit while the synchronised R/B# is low.
- R11: While an operation runs, bit 14 of the control register reads 1 and bits 5:0 show the running operation. Operation-bit writes and writes to offsets 0x04, 0x06 and 0x08 are ignored. A control write whose bits 5:0 are zero or hold more than one set bit starts nothing.
- R12: Chip enable is low while an operation runs, and also while configuration bit 7 is 1.
- R13: Writing configuration bit 6 as 1 aborts any operation and clears the completion bit. Bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| buf_addr | input | $clog2(SECTIONS*SECT_BYTES/2) | Host word address into the section buffer |
| buf_wr | input | 1 | Host buffer write strobe |
| buf_wdata | input | 16 | Host buffer write data |
| buf_rdata | output | 16 | Host buffer read data |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_rb_n | input | 1 | Ready (high) / busy (low) from the flash |
| nf_dq_i | input | 8 | Data bus input |
| nf_dq_o | output | 8 | Data bus output |
| nf_dq_oe | output | 1 | Data bus output enable |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions take two things for granted about the inputs. First, the flash pulls R/B# low within T_WB minus two cycles of the last WE# edge of a busy-causing command; otherwise the synchroniser misses it. Second, the byte on the data input is stable during the final low cycle of each RE# pulse. The bench's flash model drives R/B# low on the very WE# rising edge that latches the program command. It changes its data byte only on RE# rising edges, so every sample sits in a stable window. Section numbers written by the bench stay below SECTIONS, and each operation is started only after the previous completion has been seen.

// File: rtl/nand_op_engine.sv
module nand_op_engine #(
  parameter int SECTIONS   = 2,
  parameter int SECT_BYTES = 512,
  parameter int T_LOW      = 2,
  parameter int T_HIGH     = 2,
  parameter int T_WB       = 4,
  parameter int ID_BEATS   = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic [$clog2(SECTIONS*SECT_BYTES/2)-1:0] buf_addr,
  input  logic        buf_wr,
  input  logic [15:0] buf_wdata,
  output logic [15:0] buf_rdata,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_ce_n,
  output logic        nf_we_n,
  output logic        nf_re_n,
  input  logic        nf_rb_n,
  input  logic [7:0]  nf_dq_i,
  output logic [7:0]  nf_dq_o,
  output logic        nf_dq_oe,
  output logic        irq
);
  localparam int WORDS  = SECT_BYTES / 2;
  localparam int WORD_W = $clog2(WORDS);
  localparam int BUF_AW = $clog2(SECTIONS * WORDS);
  localparam int SEC_W  = (SECTIONS > 1) ? $clog2(SECTIONS) : 1;
  localparam int BEAT_W = $clog2(SECT_BYTES + 1);
  localparam int TW     = $clog2(T_LOW + T_HIGH + T_WB + 1);
  localparam int OP_CMD = 0, OP_ADDR = 1, OP_DIN = 2, OP_DOUT = 3, OP_ID = 4, OP_STAT = 5;

  typedef enum logic [2:0] {S_IDLE, S_RDY, S_LO, S_HI, S_TWB, S_END} st_t;

  st_t               state;
  logic [5:0]        op_q;
  logic [TW-1:0]     timer;
  logic [BEAT_W-1:0] beat;
  logic [7:0]        hold_q;
  logic [SEC_W-1:0]  sect_q;
  logic [15:0]       addr_q, cmd_q;
  logic [7:0]        cfg1_q;
  logic              done_q, rb_meta, rb_s;
  logic [15:0]       mem [SECTIONS*WORDS];

  wire busy    = (state != S_IDLE);
  wire wr_sect = reg_wr && reg_addr[4:1] == 4'd2;
  wire wr_addr = reg_wr && reg_addr[4:1] == 4'd3;
  wire wr_cmd  = reg_wr && reg_addr[4:1] == 4'd4;
  wire wr_cfg1 = reg_wr && reg_addr[4:1] == 4'd13;
  wire wr_cfg2 = reg_wr && reg_addr[4:1] == 4'd14;
  wire soft_rst = wr_cfg1 && reg_wdata[6];
  wire start   = wr_cfg2 && !busy && $onehot(reg_wdata[5:0]);
  wire big_end = cfg1_q[5];
  wire is_wr   = op_q[OP_CMD] | op_q[OP_ADDR] | op_q[OP_DIN];
  wire is_rd   = op_q[OP_DOUT] | op_q[OP_ID] | op_q[OP_STAT];
  wire strobe  = (state == S_LO);
  wire framed  = (state == S_LO) || (state == S_HI);
  wire lo_end  = strobe && timer == TW'(T_LOW - 1);

  logic [BEAT_W-1:0] nbeats;
  always_comb begin
    if (op_q[OP_DIN] || op_q[OP_DOUT]) nbeats = BEAT_W'(SECT_BYTES);
    else if (op_q[OP_ID])              nbeats = BEAT_W'(ID_BEATS);
    else                               nbeats = BEAT_W'(1);
  end
  wire last_beat = (beat == nbeats - BEAT_W'(1));

  wire [BUF_AW-1:0] sect_base = BUF_AW'(sect_q) * BUF_AW'(WORDS);
  wire [BUF_AW-1:0] data_addr = sect_base + BUF_AW'(WORD_W'(beat >> 1));

  logic              eng_we;
  logic [BUF_AW-1:0] eng_waddr;
  logic [15:0]       eng_wdata;
  always_comb begin
    eng_we    = 1'b0;
    eng_waddr = data_addr;
    eng_wdata = {8'h00, nf_dq_i};
    if (lo_end && op_q[OP_DOUT]) begin
      eng_we    = beat[0];
      eng_wdata = big_end ? {hold_q, nf_dq_i} : {nf_dq_i, hold_q};
    end else if (lo_end && op_q[OP_ID]) begin
      eng_we    = 1'b1;
      eng_waddr = BUF_AW'(beat);
    end else if (lo_end && op_q[OP_STAT]) begin
      eng_we    = 1'b1;
      eng_waddr = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (eng_we)      mem[eng_waddr] <= eng_wdata;
    else if (buf_wr) mem[buf_addr]  <= buf_wdata;
  end
  assign buf_rdata = mem[buf_addr];

  wire [15:0] din_word = mem[data_addr];
  wire [7:0]  first_b  = big_end ? din_word[15:8] : din_word[7:0];
  wire [7:0]  second_b = big_end ? din_word[7:0]  : din_word[15:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_meta <= 1'b0;
      rb_s    <= 1'b0;
    end else begin
      rb_meta <= nf_rb_n;
      rb_s    <= rb_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sect_q <= '0;
      addr_q <= '0;
      cmd_q  <= '0;
      cfg1_q <= '0;
    end else begin
      if (wr_sect && !busy) sect_q <= reg_wdata[SEC_W-1:0];
      if (wr_addr && !busy) addr_q <= reg_wdata;
      if (wr_cmd  && !busy) cmd_q  <= reg_wdata;
      if (wr_cfg1)          cfg1_q <= reg_wdata[7:0] & 8'hBC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= '0;
      timer  <= '0;
      beat   <= '0;
      hold_q <= '0;
      done_q <= 1'b0;
    end else if (soft_rst) begin
      state  <= S_IDLE;
      op_q   <= '0;
      timer  <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr_cfg2 && !reg_wdata[15]) done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_q  <= reg_wdata[5:0];
          beat  <= '0;
          timer <= '0;
          state <= reg_wdata[OP_DOUT] ? S_RDY : S_LO;
        end
        S_RDY: if (rb_s) state <= S_LO;
        S_LO: begin
          if (lo_end) begin
            timer <= '0;
            state <= S_HI;
            if (op_q[OP_DOUT] && !beat[0]) hold_q <= nf_dq_i;
          end else timer <= timer + TW'(1);
        end
        S_HI: begin
          if (timer == TW'(T_HIGH - 1)) begin
            timer <= '0;
            if (last_beat) state <= S_TWB;
            else begin
              beat  <= beat + BEAT_W'(1);
              state <= S_LO;
            end
          end else timer <= timer + TW'(1);
        end
        S_TWB: begin
          if (timer == TW'(T_WB - 1)) begin
            timer <= '0;
            state <= S_END;
          end else timer <= timer + TW'(1);
        end
        S_END: if (rb_s) begin
          state  <= S_IDLE;
          op_q   <= '0;
          done_q <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign nf_we_n  = !(strobe && is_wr);
  assign nf_re_n  = !(strobe && is_rd);
  assign nf_cle   = framed && op_q[OP_CMD];
  assign nf_ale   = framed && op_q[OP_ADDR];
  assign nf_dq_oe = framed && is_wr;
  assign nf_dq_o  = op_q[OP_CMD]  ? cmd_q[7:0] :
                    op_q[OP_ADDR] ? addr_q[7:0] :
                    (beat[0] ? second_b : first_b);
  assign nf_ce_n  = !(cfg1_q[7] || busy);
  assign irq      = done_q && !cfg1_q[4];

  always_comb begin
    case (reg_addr[4:1])
      4'd2:    reg_rdata = 16'(sect_q);
      4'd3:    reg_rdata = addr_q;
      4'd4:    reg_rdata = cmd_q;
      4'd13:   reg_rdata = {8'h00, cfg1_q};
      4'd14:   reg_rdata = {done_q, busy, 8'h00, op_q};
      default: reg_rdata = 16'h0000;
    endcase
  end

  p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(wr_cfg2 && !reg_wdata[15]) && !soft_rst) |=> done_q);

  p_done_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(rb_s));

  p_wait_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDY && !rb_s && !soft_rst) |=> state == S_RDY);

  p_op_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_cfg2 && state != S_END && !soft_rst) |=> $stable(op_q));

  p_op_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_q));

  p_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (state == S_IDLE && !done_q));
endmodule

// File: tb/nand_op_engine_tb.sv
module nand_op_engine_tb;
  localparam int TL = 2, TH = 2, SB = 512, NID = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [8:0] buf_addr = '0;
  logic buf_wr = 1'b0;
  logic [15:0] buf_wdata = '0, buf_rdata;
  logic nf_cle, nf_ale, nf_ce_n, nf_we_n, nf_re_n, nf_dq_oe, irq;
  logic nf_rb_n = 1'b1;
  logic [7:0] nf_dq_i, nf_dq_o;

  always #4 clk = ~clk;

  nand_op_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_addr(buf_addr),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_rb_n(nf_rb_n), .nf_dq_i(nf_dq_i), .nf_dq_o(nf_dq_o),
    .nf_dq_oe(nf_dq_oe), .irq(irq)
  );

  function automatic logic [7:0] fbyte(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  int rd_cnt = 0, rd_base = 0, we_pulses = 0, din_n = 0, we_lo = 0, cle_hi = 0;
  logic [7:0] last_byte = '0;
  logic last_cle = 1'b0, last_ale = 1'b0;
  logic [7:0] din_bytes [1024];

  assign nf_dq_i = fbyte(rd_cnt - rd_base);

  always @(posedge nf_re_n) rd_cnt++;
  always @(posedge nf_we_n) begin
    we_pulses++;
    last_byte = nf_dq_o;
    last_cle  = nf_cle;
    last_ale  = nf_ale;
    if (nf_cle) rd_base = rd_cnt;
    if (!nf_cle && !nf_ale && din_n < 1024) begin
      din_bytes[din_n] = nf_dq_o;
      din_n++;
    end
  end
  always @(negedge clk) begin
    if (!nf_we_n) we_lo++;
    if (nf_cle) cle_hi++;
  end

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit ended = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1;
      n_bad++;
      n_chk++;
      $display("FAIL watchdog (all R): actual %0d expected 0", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic reg_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic buf_write(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    buf_addr = a; buf_wdata = d; buf_wr = 1'b1;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic buf_read(input logic [8:0] a, output logic [15:0] d);
    @(negedge clk);
    buf_addr = a;
    #1 d = buf_rdata;
  endtask

  task automatic wait_done(output logic [15:0] v);
    for (int i = 0; i < 6000; i++) begin
      reg_read(5'h1C, v);
      if (v[15]) break;
    end
  endtask

  task automatic run_op(input logic [15:0] opbits);
    logic [15:0] v;
    reg_write(5'h1C, opbits);
    wait_done(v);
  endtask

  localparam logic [8:0] VEC [9] = '{
    {1'b0, 8'hFF}, {1'b0, 8'h00}, {1'b0, 8'h30}, {1'b0, 8'h90}, {1'b0, 8'h70},
    {1'b1, 8'h00}, {1'b1, 8'h5A}, {1'b1, 8'hA5}, {1'b1, 8'hFF}
  };

  initial begin
    logic [15:0] v, w;
    int p0, l0, c0, r0, d0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    begin
      logic [15:0] acc;
      acc = '0;
      foreach (VEC[k]) ;
      reg_read(5'h04, v); acc |= v;
      reg_read(5'h06, v); acc |= v;
      reg_read(5'h08, v); acc |= v;
      reg_read(5'h1A, v); acc |= v;
      reg_read(5'h1C, v); acc |= v;
      check(acc == 16'h0, "R1 registers after reset", acc, 0);
      check({nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, irq} == 6'b111000,
            "R1 pins after reset", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, irq}, 6'b111000);
    end

    // R2 / R3 table of latch operations
    for (int k = 0; k < 9; k++) begin
      logic is_addr;
      logic [7:0] b;
      {is_addr, b} = VEC[k];
      reg_write(is_addr ? 5'h06 : 5'h08, {8'h00, b});
      p0 = we_pulses; l0 = we_lo; c0 = cle_hi;
      run_op(is_addr ? 16'h0002 : 16'h0001);
      reg_read(5'h1C, v);
      check(v[15], is_addr ? "R3 done" : "R2 done", v, 16'h8000);
      check(we_pulses - p0 == 1, is_addr ? "R3 pulse count" : "R2 pulse count", we_pulses - p0, 1);
      check(last_byte == b, is_addr ? "R3 bus byte" : "R2 bus byte", last_byte, b);
      check(last_cle == !is_addr && last_ale == is_addr, is_addr ? "R3 ALE/CLE" : "R2 ALE/CLE",
            {last_cle, last_ale}, {!is_addr, is_addr});
      check(we_lo - l0 == TL, is_addr ? "R3 WE low width" : "R2 WE low width", we_lo - l0, TL);
      check(cle_hi - c0 == (is_addr ? 0 : TL + TH), is_addr ? "R3 CLE cycles" : "R2 CLE cycles",
            cle_hi - c0, is_addr ? 0 : TL + TH);
    end

    // R4 / R5 completion and interrupt
    check(irq == 1'b1, "R5 irq with mask clear", irq, 1);
    reg_write(5'h1A, 16'h0010);
    #1 check(irq == 1'b0, "R5 irq masked", irq, 0);
    reg_write(5'h1A, 16'h0000);
    reg_write(5'h1C, 16'h8000);
    reg_read(5'h1C, v);
    check(v[15] && irq, "R4 writing 1 keeps done", v, 16'h8000);
    reg_write(5'h1C, 16'h0000);
    reg_read(5'h1C, v);
    check(!v[15] && !irq, "R4 writing 0 clears done", v, 0);

    // R11 invalid operation codes start nothing
    p0 = we_pulses;
    reg_write(5'h1C, 16'h0003);
    repeat (10) @(negedge clk);
    reg_read(5'h1C, v);
    check(v == 16'h0 && we_pulses == p0 && nf_ce_n, "R11 multi-bit op ignored", v, 0);

    // R12 forced chip enable
    reg_write(5'h1A, 16'h0080);
    #1 check(nf_ce_n == 1'b0, "R12 forced CE", nf_ce_n, 0);
    reg_write(5'h1A, 16'h0000);
    #1 check(nf_ce_n == 1'b1, "R12 CE released", nf_ce_n, 1);

    // R7 write-in from section 1, with R11 busy checks
    for (int i = 0; i < 256; i++) buf_write(9'(256 + i), 16'(i * 16'h0301 ^ 16'h3C5A));
    reg_write(5'h08, 16'h0080);
    reg_write(5'h04, 16'h0001);
    d0 = din_n; p0 = we_pulses; l0 = we_lo;
    reg_write(5'h1C, 16'h0004);
    repeat (20) @(negedge clk);
    reg_read(5'h1C, v);
    check(v[14] && v[5:0] == 6'h04, "R11 busy and op readable", v, 16'h4004);
    check(!nf_ce_n, "R12 CE low while busy", nf_ce_n, 0);
    reg_write(5'h1C, 16'h0001);
    reg_write(5'h08, 16'h0055);
    reg_write(5'h04, 16'h0000);
    wait_done(v);
    reg_read(5'h08, w);
    check(w == 16'h0080, "R11 command register held while busy", w, 16'h0080);
    reg_read(5'h04, w);
    check(w == 16'h0001, "R11 section register held while busy", w, 1);
    check(we_pulses - p0 == SB, "R7/R11 pulse count", we_pulses - p0, SB);
    check(din_n - d0 == SB, "R7 data bytes", din_n - d0, SB);
    check(we_lo - l0 == SB * TL, "R7 WE low cycles", we_lo - l0, SB * TL);
    begin
      int bad = 0;
      for (int i = 0; i < SB; i++) begin
        logic [15:0] ww;
        ww = 16'((i / 2) * 16'h0301 ^ 16'h3C5A);
        if (din_bytes[d0 + i] != ((i % 2) ? ww[15:8] : ww[7:0])) bad++;
      end
      check(bad == 0, "R7 byte order little-endian", bad, 0);
    end

    // R6 read-out into section 1, gated by R/B#
    reg_write(5'h08, 16'h0000);
    run_op(16'h0001);
    nf_rb_n = 1'b0;
    r0 = rd_cnt;
    reg_write(5'h1C, 16'h0008);
    repeat (30) @(negedge clk);
    reg_read(5'h1C, v);
    check(rd_cnt == r0 && v[14], "R6 waits for ready", rd_cnt - r0, 0);
    nf_rb_n = 1'b1;
    wait_done(v);
    check(rd_cnt - r0 == SB, "R6 RE pulse count", rd_cnt - r0, SB);
    for (int i = 0; i < 256; i++) begin
      buf_read(9'(256 + i), w);
      check(w == {fbyte(2 * i + 1), fbyte(2 * i)}, "R6 little-endian word", w,
            {fbyte(2 * i + 1), fbyte(2 * i)});
    end
    reg_write(5'h1A, 16'h0020);
    run_op(16'h0001);
    reg_write(5'h04, 16'h0000);
    run_op(16'h0008);
    for (int i = 0; i < 256; i++) begin
      buf_read(9'(i), w);
      check(w == {fbyte(2 * i), fbyte(2 * i + 1)}, "R6 big-endian word", w,
            {fbyte(2 * i), fbyte(2 * i + 1)});
    end
    reg_write(5'h1A, 16'h0000);

    // R8 ID read
    reg_write(5'h08, 16'h0090);
    run_op(16'h0001);
    reg_write(5'h06, 16'h0000);
    run_op(16'h0002);
    run_op(16'h0010);
    for (int k = 0; k < NID; k++) begin
      buf_read(9'(k), w);
      check(w == {8'h00, fbyte(k)}, "R8 ID beat word", w, {8'h00, fbyte(k)});
    end
    buf_read(9'(NID), w);
    check(w == {fbyte(2 * NID), fbyte(2 * NID + 1)}, "R8 word past ID untouched", w,
          {fbyte(2 * NID), fbyte(2 * NID + 1)});

    // R9 status read
    reg_write(5'h08, 16'h0070);
    run_op(16'h0001);
    r0 = rd_cnt;
    run_op(16'h0020);
    check(rd_cnt - r0 == 1, "R9 single RE pulse", rd_cnt - r0, 1);
    buf_read(9'd0, w);
    check(w == {8'h00, fbyte(0)}, "R9 status word", w, {8'h00, fbyte(0)});
    buf_read(9'd1, w);
    check(w == {8'h00, fbyte(1)}, "R9 word 1 untouched", w, {8'h00, fbyte(1)});

    // R10 completion withheld while busy after program command
    reg_write(5'h08, 16'h0010);
    reg_write(5'h1C, 16'h0001);
    @(posedge nf_we_n);
    nf_rb_n = 1'b0;
    repeat (30) @(negedge clk);
    reg_read(5'h1C, v);
    check(!v[15] && v[14], "R10 done held while R/B# low", v, 16'h4001);
    nf_rb_n = 1'b1;
    wait_done(v);
    check(v[15], "R10 done after ready", v, 16'h8000);

    // R13 abort
    reg_write(5'h04, 16'h0001);
    reg_write(5'h1C, 16'h0004);
    repeat (50) @(negedge clk);
    reg_write(5'h1A, 16'h0040);
    reg_read(5'h1C, v);
    check(v == 16'h0000, "R13 abort clears busy and done", v, 0);
    reg_read(5'h1A, v);
    check(v == 16'h0000, "R13 reset bit reads 0", v, 0);
    p0 = we_pulses;
    repeat (20) @(negedge clk);
    check(we_pulses == p0 && nf_ce_n, "R13 bus idle after abort", we_pulses - p0, 0);

    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule